// File: doc/BRIEF.md
# Segmented Waveform RAM Playback Engine

This block reads stored waveform words out of a RAM and turns each one into a pair of 16-bit I and Q samples. The range of RAM addresses it walks is set by the active segment, which gives a start address, an end address, a 16-bit step word and a 3-bit playback mode. The samples go to one of two consumers. The scaling multipliers take one sample every 4·R·M system clocks, where R is the interpolation factor and M is the segment step word. The baseband path takes one sample on each cycle in which the baseband data clock enable is high.

A transition on the segment-select input, rising or falling, hands control to the segment whose fields are on the inputs and restarts the walk. Mode 2 is the exception: there the select level sets the ramp direction. When the multipliers are the destination, an update or profile-change strobe silences the outputs. They stay at zero until the next select transition. The RAM read port is asynchronous, so its data follows the address the engine presents in the same cycle.

Top module: `ram_playback_engine`

## Requirements
- R1: Each sample takes the I value from bits 31:16 and the Q value from bits 15:0 of the RAM word at the current playback address.
- R2: With the multiplier destination (`dest_bb`=0), valid samples come exactly 4·R·M cycles apart. The first sample appears in the cycle after a restart or after enabling.
- R3: With the baseband destination (`dest_bb`=1), a sample is produced in the cycle after each cycle that has `bb_tick` high, and in no other cycle.
- R4: A change of `seg_sel` in either direction restarts playback at the segment start address with the ramp direction upward. No sample is produced in that cycle. This applies to every mode except mode 2.
- R5: Mode code 0, and the unused codes 5 to 7, deliver the start word on every sample.
- R6: Mode code 1 steps upward one address per sample until it reaches the end address, then repeats the end word.
- R7: Mode code 2 steps upward toward the end while `seg_sel` is high and downward toward the start while it is low. It holds at the bound it reaches. A select transition does not move the address.
- R8: Mode code 3 steps upward to the end, then downward to the start, and keeps bouncing between the two bounds. If start equals end it holds.
- R9: Mode code 4 steps upward to the end and then wraps to the start, repeating without end.
- R10: A step word of 0 and an interpolation factor of 0 are each treated as 1.
- R11: With the RAM enabled and the multiplier destination, a strobe on `update_stb` or `profile_stb` drives I and Q to zero and drops valid from the next cycle. With the baseband destination, both strobes are ignored.
- R12: Once zeroed, the outputs stay at zero with no valid samples until a `seg_sel` transition resumes playback. This holds even if a strobe arrives in the same cycle as that transition, because the strobe wins.
- R13: While `ram_en` is low, I, Q and valid are zero and the read address sits at the segment start. Reset gives the same output state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_en | input | 1 | Playback enable |
| dest_bb | input | 1 | 0: scaling multipliers, 1: baseband path |
| seg_start | input | 10 | Active segment start address |
| seg_end | input | 10 | Active segment end address (not below start) |
| seg_step | input | 16 | Active segment step word M |
| seg_mode | input | 3 | Active segment playback mode |
| interp_fact | input | 8 | Interpolation factor R |
| update_stb | input | 1 | Update strobe |
| profile_stb | input | 1 | Profile-change strobe |
| seg_sel | input | 1 | Segment-select level; transitions restart playback |
| bb_tick | input | 1 | Baseband data clock enable |
| rd_addr | output | 10 | RAM read address |
| rd_data | input | 32 | RAM read data for `rd_addr` |
| i_out | output | 16 | I sample |
| q_out | output | 16 | Q sample |
| out_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
Some behaviours are checked on every cycle by assertions. A strobe silences the outputs one cycle later. A disabled engine stays idle at the start address. Mode 1 stays parked on its end word. Mode 4 wraps from end to start. In multiplier mode, two samples never come in back-to-back cycles. Other behaviours need the bench's reference model, which tracks every cycle. These are the exact 4·R·M spacing for several R and M values, the treatment of zero as one, the ordering of addresses in each mode (the bounce points of mode 3 and the level-driven direction of mode 2), the I/Q split of the RAM word, and playback resuming only on a select transition.

// File: rtl/ram_pb_pkg.sv
package ram_pb_pkg;

    localparam logic [2:0] PB_HOLD     = 3'd0;
    localparam logic [2:0] PB_RAMP     = 3'd1;
    localparam logic [2:0] PB_BIDIR    = 3'd2;
    localparam logic [2:0] PB_PINGPONG = 3'd3;
    localparam logic [2:0] PB_LOOP     = 3'd4;

endpackage

// File: rtl/pb_rate_timer.sv
module pb_rate_timer #(
    parameter int STEP_W = 16,
    parameter int FACT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              use_bb,
    input  logic              bb_tick,
    input  logic [STEP_W-1:0] step_word,
    input  logic [FACT_W-1:0] interp_fact,
    output logic              tick
);
    localparam int CNT_W = STEP_W + FACT_W + 2;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] span_m1;
    logic [CNT_W-1:0] m_eff, r_eff;

    always_comb begin
        m_eff   = (step_word == '0)   ? CNT_W'(1) : CNT_W'(step_word);
        r_eff   = (interp_fact == '0) ? CNT_W'(1) : CNT_W'(interp_fact);
        span_m1 = ((m_eff * r_eff) << 2) - CNT_W'(1);
        tick    = run && (use_bb ? bb_tick : (cnt_q == '0));
        cnt_d   = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && !use_bb) begin
            cnt_d = (cnt_q == '0) ? span_m1 : cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !use_bb && !clear) |=> !(tick && !use_bb));

endmodule

// File: rtl/pb_addr_stepper.sv
module pb_addr_stepper
    import ram_pb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stop_addr,
    input  logic              dir_up,
    input  logic              level,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              nxt_up
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        nxt_addr = addr;
        nxt_up   = dir_up;
        case (mode)
            PB_RAMP: begin
                if (addr < stop_addr) nxt_addr = addr + ONE;
            end
            PB_BIDIR: begin
                if (level) begin
                    if (addr < stop_addr) nxt_addr = addr + ONE;
                end else begin
                    if (addr > start_addr) nxt_addr = addr - ONE;
                end
            end
            PB_PINGPONG: begin
                if (start_addr != stop_addr) begin
                    if (dir_up) begin
                        if (addr >= stop_addr) begin
                            nxt_up   = 1'b0;
                            nxt_addr = addr - ONE;
                        end else begin
                            nxt_addr = addr + ONE;
                        end
                    end else begin
                        if (addr <= start_addr) begin
                            nxt_up   = 1'b1;
                            nxt_addr = addr + ONE;
                        end else begin
                            nxt_addr = addr - ONE;
                        end
                    end
                end
            end
            PB_LOOP: begin
                nxt_addr = (addr >= stop_addr) ? start_addr : addr + ONE;
            end
            default: begin
                nxt_addr = start_addr;
            end
        endcase
    end

endmodule

// File: rtl/ram_playback_engine.sv
module ram_playback_engine
    import ram_pb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SAMP_W = 16,
    parameter int STEP_W = 16,
    parameter int FACT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ram_en,
    input  logic                dest_bb,
    input  logic [ADDR_W-1:0]   seg_start,
    input  logic [ADDR_W-1:0]   seg_end,
    input  logic [STEP_W-1:0]   seg_step,
    input  logic [2:0]          seg_mode,
    input  logic [FACT_W-1:0]   interp_fact,
    input  logic                update_stb,
    input  logic                profile_stb,
    input  logic                seg_sel,
    input  logic                bb_tick,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [2*SAMP_W-1:0] rd_data,
    output logic [SAMP_W-1:0]   i_out,
    output logic [SAMP_W-1:0]   q_out,
    output logic                out_valid
);
    localparam int WORD_W = 2 * SAMP_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              dir_up;
        logic              zero;
        logic              sel_prev;
        logic [SAMP_W-1:0] i_s;
        logic [SAMP_W-1:0] q_s;
        logic              valid;
    } pb_state_t;

    pb_state_t st_d, st_q;

    logic              trans, restart, run, clear, tick, silence;
    logic [ADDR_W-1:0] step_addr;
    logic              step_up;

    assign trans   = (seg_sel != st_q.sel_prev);
    assign restart = trans && (seg_mode != PB_BIDIR);
    assign run     = ram_en && !st_q.zero && !trans;
    assign clear   = !ram_en || restart;
    assign silence = ram_en && !dest_bb && (update_stb || profile_stb);

    pb_rate_timer #(
        .STEP_W (STEP_W),
        .FACT_W (FACT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .run         (run),
        .use_bb      (dest_bb),
        .bb_tick     (bb_tick),
        .step_word   (seg_step),
        .interp_fact (interp_fact),
        .tick        (tick)
    );

    pb_addr_stepper #(
        .ADDR_W (ADDR_W)
    ) u_stepper (
        .mode       (seg_mode),
        .addr       (st_q.addr),
        .start_addr (seg_start),
        .stop_addr  (seg_end),
        .dir_up     (st_q.dir_up),
        .level      (seg_sel),
        .nxt_addr   (step_addr),
        .nxt_up     (step_up)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sel_prev = seg_sel;
        st_d.valid    = 1'b0;
        if (!ram_en) begin
            st_d.addr   = seg_start;
            st_d.dir_up = 1'b1;
            st_d.zero   = 1'b0;
            st_d.i_s    = '0;
            st_d.q_s    = '0;
        end else begin
            if (trans) begin
                st_d.zero = 1'b0;
                if (restart) begin
                    st_d.addr   = seg_start;
                    st_d.dir_up = 1'b1;
                end
            end else if (tick) begin
                st_d.i_s    = rd_data[WORD_W-1:SAMP_W];
                st_d.q_s    = rd_data[SAMP_W-1:0];
                st_d.valid  = 1'b1;
                st_d.addr   = step_addr;
                st_d.dir_up = step_up;
            end
            if (silence) begin
                st_d.zero  = 1'b1;
                st_d.i_s   = '0;
                st_d.q_s   = '0;
                st_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, dir_up: 1'b1, zero: 1'b0, sel_prev: 1'b0,
                      i_s: '0, q_s: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr   = st_q.addr;
    assign i_out     = st_q.i_s;
    assign q_out     = st_q.q_s;
    assign out_valid = st_q.valid;

    // R11
    strobe_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        silence |=> (i_out == '0 && q_out == '0 && !out_valid));

    // R13
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |=> (!out_valid && i_out == '0 && q_out == '0
                     && rd_addr == $past(seg_start)));

    // R12
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && st_q.zero && !trans) |=> !out_valid);

    // R6
    ramp_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !trans && seg_mode == PB_RAMP && rd_addr == seg_end)
        |=> rd_addr == $past(seg_end));

    // R9
    loop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && tick && seg_mode == PB_LOOP && rd_addr == seg_end)
        |=> rd_addr == $past(seg_start));

endmodule

// File: tb/ram_playback_engine_bench.sv
module ram_playback_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_en = 1'b0;
    logic        dest_bb = 1'b0;
    logic [9:0]  seg_start = '0;
    logic [9:0]  seg_end = '0;
    logic [15:0] seg_step = 16'd1;
    logic [2:0]  seg_mode = '0;
    logic [7:0]  interp_fact = 8'd1;
    logic        update_stb = 1'b0;
    logic        profile_stb = 1'b0;
    logic        seg_sel = 1'b0;
    logic        bb_tick = 1'b0;
    logic [9:0]  rd_addr;
    logic [31:0] rd_data;
    logic [15:0] i_out, q_out;
    logic        out_valid;

    logic [31:0] mem [1024];

    always #4 clk = ~clk;

    assign rd_data = mem[rd_addr];

    ram_playback_engine u_ram_playback_engine (
        .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .dest_bb(dest_bb),
        .seg_start(seg_start), .seg_end(seg_end), .seg_step(seg_step),
        .seg_mode(seg_mode), .interp_fact(interp_fact),
        .update_stb(update_stb), .profile_stb(profile_stb),
        .seg_sel(seg_sel), .bb_tick(bb_tick), .rd_addr(rd_addr),
        .rd_data(rd_data), .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    int    tests = 0;
    int    fails = 0;
    bit    done = 0;
    bit    checking = 0;
    string cur_req = "R13";

    // behavioural reference state
    int m_addr, m_cnt, m_i, m_q;
    bit m_up, m_zero, m_prev, m_v;

    function automatic int span(int r, int m);
        int re = (r == 0) ? 1 : r;
        int me = (m == 0) ? 1 : m;
        return 4 * re * me - 1;
    endfunction

    task automatic advance();
        int s = seg_start;
        int e = seg_end;
        case (int'(seg_mode))
            1: if (m_addr < e) m_addr++;
            2: if (seg_sel) begin if (m_addr < e) m_addr++; end
               else begin if (m_addr > s) m_addr--; end
            3: if (s != e) begin
                   if (m_up) begin
                       if (m_addr >= e) begin m_up = 0; m_addr--; end else m_addr++;
                   end else begin
                       if (m_addr <= s) begin m_up = 1; m_addr++; end else m_addr--;
                   end
               end
            4: m_addr = (m_addr >= e) ? s : m_addr + 1;
            default: m_addr = s;
        endcase
    endtask

    always @(posedge clk) begin
        bit tr, tk;
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_up = 1; m_zero = 0; m_prev = 0;
            m_i = 0; m_q = 0; m_v = 0;
        end else begin
            tr = (seg_sel != m_prev);
            m_prev = seg_sel;
            m_v = 0;
            if (!ram_en) begin
                m_addr = seg_start; m_cnt = 0; m_up = 1; m_zero = 0;
                m_i = 0; m_q = 0;
            end else begin
                if (tr) begin
                    m_zero = 0;
                    if (seg_mode != 3'd2) begin
                        m_addr = seg_start; m_cnt = 0; m_up = 1;
                    end
                end else if (!m_zero) begin
                    tk = dest_bb ? bb_tick : (m_cnt == 0);
                    if (!dest_bb) m_cnt = (m_cnt == 0) ? span(interp_fact, seg_step) : m_cnt - 1;
                    if (tk) begin
                        m_i = mem[m_addr][31:16];
                        m_q = mem[m_addr][15:0];
                        m_v = 1;
                        advance();
                    end
                end
                if (!dest_bb && (update_stb || profile_stb)) begin
                    m_zero = 1; m_i = 0; m_q = 0; m_v = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && checking && !done) begin
            tests++;
            if (out_valid !== m_v || int'(i_out) != m_i || int'(q_out) != m_q) begin
                fails++;
                $display("FAIL %s: valid/i/q actual %0b/%h/%h expected %0b/%h/%h",
                         cur_req, out_valid, i_out, q_out, m_v, m_i[15:0], m_q[15:0]);
            end
        end
    end

    task automatic cycles(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bb_tick = ((k % 3) != 1);
        end
    endtask

    task automatic flip_sel();
        @(negedge clk);
        seg_sel = ~seg_sel;
    endtask

    task automatic segment(int s, int e, int st, int md);
        @(negedge clk);
        seg_start = 10'(s); seg_end = 10'(e); seg_step = 16'(st); seg_mode = 3'(md);
    endtask

    task automatic strobe(bit prof);
        @(negedge clk);
        if (prof) profile_stb = 1'b1; else update_stb = 1'b1;
        @(negedge clk);
        profile_stb = 1'b0; update_stb = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 1024; k++)
            mem[k] = {16'(k * 3 + 16'h1000), 16'(~k)};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        tests++;
        if (out_valid !== 1'b0 || i_out !== 16'h0 || q_out !== 16'h0) begin
            fails++;
            $display("FAIL R13: reset outputs actual %0b/%h/%h expected 0/0000/0000",
                     out_valid, i_out, q_out);
        end
        checking = 1;
        // R9 recirculate, R2 spacing 8, R1 word split
        cur_req = "R9";
        segment(5, 9, 2, 4);
        ram_en = 1'b1;
        cycles(90);
        // R10 zero step and zero factor act as one
        cur_req = "R10";
        seg_step = 16'd0; interp_fact = 8'd0;
        cycles(40);
        // R2 R=3, M=1 gives 12 cycles
        cur_req = "R2";
        seg_step = 16'd1; interp_fact = 8'd3;
        cycles(60);
        interp_fact = 8'd1;
        // R5 and R4 restart on a falling and a rising transition
        cur_req = "R5/R4";
        segment(12, 15, 1, 0);
        flip_sel();
        cycles(20);
        flip_sel();
        cycles(20);
        // R6 ramp and park
        cur_req = "R6";
        segment(20, 23, 1, 1);
        flip_sel();
        cycles(60);
        // R8 ping-pong
        cur_req = "R8";
        segment(30, 33, 1, 3);
        flip_sel();
        cycles(80);
        // R7 level-driven direction
        cur_req = "R7";
        segment(40, 44, 1, 2);
        flip_sel();
        cycles(40);
        flip_sel();
        cycles(40);
        // R11 silence, R12 resume only on transition
        cur_req = "R11/R12";
        segment(50, 56, 1, 4);
        flip_sel();
        cycles(30);
        strobe(0);
        cycles(30);
        strobe(1);
        cycles(10);
        flip_sel();
        cycles(40);
        // R3 baseband rate; strobes ignored there (R11); R1 split
        cur_req = "R3/R1";
        dest_bb = 1'b1;
        segment(60, 66, 1, 4);
        flip_sel();
        cycles(30);
        strobe(0);
        cycles(30);
        dest_bb = 1'b0;
        // R13 disable mid-run then re-enable
        cur_req = "R13";
        cycles(10);
        ram_en = 1'b0;
        cycles(12);
        ram_en = 1'b1;
        cycles(30);
        summary();
    end

endmodule